// File: doc/BRIEF.md
# Multi-Mode Serial Transmitter

This block is the transmit half of a serial port. Software writes a byte into a single holding register. The block moves that byte into a frame shifter at a bit-rate tick and drives the serial line from the shifter. A transmit-empty flag tells software when the holding register can take the next byte. A masked copy of that flag acts as the interrupt request. Because the holding register and the shifter are separate, software can queue a second byte while the first is still on the line.

There are three framings:
- **Plain asynchronous:** a low start bit, eight data bits sent least significant bit first, then one or two high stop bits.
- **Flagged asynchronous:** the same frame with an address/data flag bit added after the last data bit.
- **Clocked synchronous:** the eight data bits only, with a shift clock driven alongside. The shift clock idles high and falls when the data changes. Every transfer in this mode starts from a byte write, so receive-only use still needs a dummy byte.

Clearing the enable stops acceptance of new bytes and forces the empty flag high. A byte that was written before the enable dropped is still sent.

Top module: `sio_tx`

## Requirements
- R1: After reset, `ser_out` is 1, `sck` is 1, `tx_empty` is 1 and `irq` is 0.
- R2: A write strobe while the transmitter runs clears `tx_empty` at the next clock edge.
- R3: `tx_empty` returns to 1 at the edge where the held byte moves into the shifter. `irq` equals `tx_empty` AND `irq_en`.
- R4: With `mode` = 2'b00 (2'b11 behaves the same), each frame is:
  - a 0 start bit,
  - data bits 0 to 7 in that order,
  - then one stop bit of 1, or two when `two_stop` = 1.
  
  Each bit lasts from one `bit_tick` to the next.
- R5: With `mode` = 2'b01, the value of `addr_flag` is sent as one extra bit between data bit 7 and the stop bits.
- R6: With `mode` = 2'b10, a frame is data bits 0 to 7 only. Each bit lasts two ticks: `sck` is 0 for the first tick and 1 for the second. `sck` and `ser_out` are 1 whenever no frame is active.
- R7: If a byte is waiting when a frame's last bit ends, the next frame begins on that same tick with no idle gap.
- R8: The transmitter runs when `tx_en` = 1, or, in mode 2'b10 only, when `rx_en` = 1. When it does not run, `tx_empty` is 1 from the next edge.
- R9: A byte written before the transmitter stopped running is still sent completely, after any frame already in progress.
- R10: A write strobe while the transmitter does not run is ignored: the line stays idle and `tx_empty` stays 1.
- R11: In mode 2'b10 with `rx_en` = 1 and `tx_en` = 0, a written byte is transmitted like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| mode | input | 2 | Framing select: 00 plain async, 01 flagged async, 10 synchronous |
| two_stop | input | 1 | Two stop bits when 1 (asynchronous modes) |
| addr_flag | input | 1 | Value of the address/data flag bit in mode 01 |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, also keeps the transmitter running in mode 10 |
| irq_en | input | 1 | Interrupt mask |
| ser_out | output | 1 | Serial data line |
| sck | output | 1 | Shift clock for synchronous mode, 1 otherwise |
| tx_empty | output | 1 | Holding register may be written |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `mode`, `two_stop` and `addr_flag` change only while no frame is active and no byte is waiting. They also assume `bit_tick` pulses for a single cycle with at least two cycles between pulses. The stimulus keeps to these conditions:
- It changes the framing inputs only after waiting several bit periods past the last captured bit.
- It derives the tick from a free-running divide-by-four counter.
- It writes a second byte only after the empty flag has risen, so the holding register is never overwritten.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'b00,
    MODE_ASYNC_AD = 2'b01,
    MODE_SYNC     = 2'b10,
    MODE_RSVD     = 2'b11
  } sio_mode_e;
endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          run,
  input  logic          load,
  output logic          hold_full,
  output logic [DW-1:0] hold_data,
  output logic          tx_empty
);
  logic          full_d, empty_d, data_en;
  logic [DW-1:0] data_d;

  assign data_en = wr_stb && run;

  always_comb begin
    full_d = hold_full;
    if (load)    full_d = 1'b0;
    if (data_en) full_d = 1'b1;
    data_d = data_en ? wr_data : hold_data;
    empty_d = tx_empty;
    if (!run)         empty_d = 1'b1;
    else if (wr_stb)  empty_d = 1'b0;
    else if (load)    empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      tx_empty  <= 1'b1;
    end else begin
      hold_full <= full_d;
      tx_empty  <= empty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) hold_data <= data_d;
  end
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
  import sio_tx_pkg::*;
#(
  parameter  int DW = 8,
  localparam int FW = DW + 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  sio_mode_e     mode,
  input  logic          two_stop,
  input  logic          addr_flag,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          load,
  output logic          busy,
  output logic          ser_out,
  output logic          sck
);
  logic          busy_q, busy_d, sync_q, sync_d, phase_q, phase_d;
  logic [FW-1:0] sreg_q, sreg_d, frame;
  logic [CW-1:0] cnt_q, cnt_d, flen;
  logic          ld_sync, ld_ad, last_bit;

  // frame image for the byte waiting in the holding register
  always_comb begin
    ld_sync = (mode == MODE_SYNC);
    ld_ad   = (mode == MODE_ASYNC_AD);
    frame   = '1;
    if (ld_sync) begin
      frame[DW-1:0] = hold_data;
      flen          = CW'(DW);
    end else begin
      frame[0]    = 1'b0;
      frame[DW:1] = hold_data;
      if (ld_ad) frame[DW+1] = addr_flag;
      flen = CW'(DW + 2 + (ld_ad ? 1 : 0) + (two_stop ? 1 : 0));
    end
  end

  assign last_bit = busy_q && (cnt_q == '0) && (!sync_q || phase_q);
  assign load     = bit_tick && hold_full && (!busy_q || last_bit);

  always_comb begin
    busy_d  = busy_q;
    sync_d  = sync_q;
    phase_d = phase_q;
    sreg_d  = sreg_q;
    cnt_d   = cnt_q;
    if (load) begin
      busy_d  = 1'b1;
      sync_d  = ld_sync;
      phase_d = 1'b0;
      sreg_d  = frame;
      cnt_d   = flen - CW'(1);
    end else if (bit_tick && busy_q) begin
      if (last_bit) begin
        busy_d  = 1'b0;
        phase_d = 1'b0;
      end else if (sync_q && !phase_q) begin
        phase_d = 1'b1;
      end else begin
        sreg_d  = {1'b1, sreg_q[FW-1:1]};
        cnt_d   = cnt_q - CW'(1);
        phase_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sync_q  <= 1'b0;
      phase_q <= 1'b0;
      sreg_q  <= '1;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      sync_q  <= sync_d;
      phase_q <= phase_d;
      sreg_q  <= sreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign ser_out = busy_q ? sreg_q[0] : 1'b1;
  assign sck     = (busy_q && sync_q) ? phase_q : 1'b1;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    mode,
  input  logic          two_stop,
  input  logic          addr_flag,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          irq_en,
  output logic          ser_out,
  output logic          sck,
  output logic          tx_empty,
  output logic          irq
);
  sio_mode_e     mode_e;
  logic          run, load, busy, hold_full;
  logic [DW-1:0] hold_data;

  assign mode_e = sio_mode_e'(mode);
  assign run    = tx_en || ((mode_e == MODE_SYNC) && rx_en);

  sio_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .run(run), .load(load), .hold_full(hold_full),
    .hold_data(hold_data), .tx_empty(tx_empty)
  );

  sio_tx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode(mode_e),
    .two_stop(two_stop), .addr_flag(addr_flag), .hold_full(hold_full),
    .hold_data(hold_data), .load(load), .busy(busy),
    .ser_out(ser_out), .sck(sck)
  );

  assign irq = tx_empty && irq_en;
endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic wr_stb,
  input logic load,
  input logic busy,
  input logic hold_full,
  input logic tx_empty,
  input logic ser_out,
  input logic sck
);
  // R2
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && run) |=> !tx_empty);
  // R3
  load_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_stb && run) |=> tx_empty);
  // R8
  halt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> tx_empty);
  // R6
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_out && sck));
  // R10
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold_full) |=> !hold_full);
  // R9
  keep_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> hold_full);
endmodule

bind sio_tx sio_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wr_stb(wr_stb), .load(load),
  .busy(busy), .hold_full(hold_full), .tx_empty(tx_empty),
  .ser_out(ser_out), .sck(sck)
);

// File: tb/sim_sio_tx.sv
`timescale 1ns/1ps
module sim_sio_tx;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 1'b0, two_stop = 1'b0, addr_flag = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode = 2'b00;
  logic ser_out, sck, tx_empty, irq, bit_tick;
  int tcnt = 0, n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  always @(negedge clk) tcnt <= (tcnt == DIV-1) ? 0 : tcnt + 1;
  assign bit_tick = (tcnt == DIV-1);

  sio_tx u0 (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .mode(mode), .two_stop(two_stop), .addr_flag(addr_flag),
    .tx_en(tx_en), .rx_en(rx_en), .irq_en(irq_en), .ser_out(ser_out),
    .sck(sck), .tx_empty(tx_empty), .irq(irq));

  task automatic step; @(negedge clk); #1; endtask
  task automatic next_tick; do step; while (!bit_tick); endtask
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d; step; wr_stb = 1'b0;
  endtask
  task automatic wait_empty; while (!tx_empty) step; endtask
  task automatic cap_a(input int n, output logic [63:0] v);
    v = '0;
    while (ser_out) step;
    for (int k = 0; k < n; k++) begin next_tick; v[k] = ser_out; end
  endtask
  task automatic cap_s(input int n, output logic [63:0] v);
    v = '0;
    for (int k = 0; k < n; k++) begin
      while (sck) step;
      while (!sck) step;
      v[k] = ser_out;
    end
  endtask
  function automatic int alen(input bit ad, input bit ts);
    return 10 + (ad ? 1 : 0) + (ts ? 1 : 0);
  endfunction
  function automatic logic [63:0] afr(input logic [7:0] d, input bit ad, input bit fl, input bit ts);
    logic [63:0] v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++) v[1+i] = d[i];
    if (ad) v[9] = fl;
    return v & ((64'd1 << alen(ad, ts)) - 64'd1);
  endfunction
  function automatic logic [7:0] pat(input int i);
    case (i)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'hA5;
      3: return 8'h5A; 4: return 8'h01; default: return 8'h80;
    endcase
  endfunction

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] got, exp;
    int la, bad;
    repeat (3) step;
    // R1 reset state
    chk(ser_out && sck && tx_empty && !irq, "R1", {ser_out, sck, tx_empty, irq}, 4'b1110);
    rst_n = 1'b1; tx_en = 1'b1; irq_en = 1'b1;
    step;
    // R4 R5 R7 R2 R3: async sweep, two bytes back to back
    for (int m = 0; m < 2; m++)
      for (int ts = 0; ts < 2; ts++)
        for (int di = 0; di < 6; di++) begin
          mode = 2'(m); two_stop = ts[0]; addr_flag = di[0];
          wr(pat(di));
          chk(!tx_empty, "R2", tx_empty, 0);
          wait_empty;
          chk(irq, "R3", irq, 1);
          wr(pat(5 - di));
          la = alen(m[0], ts[0]);
          cap_a(2 * la, got);
          exp = (afr(pat(5 - di), m[0], di[0], ts[0]) << la) | afr(pat(di), m[0], di[0], ts[0]);
          chk(got == exp, m[0] ? "R5" : (ts[0] ? "R4 R7 stop2" : "R4 R7"), got, exp);
          repeat (4 * DIV) step;
        end
    // R6 R7: synchronous sweep
    mode = 2'b10;
    for (int di = 0; di < 6; di++) begin
      wr(pat(di));
      wait_empty;
      chk(!sck, "R6 sck low", sck, 0);
      wr(pat(5 - di));
      cap_s(16, got);
      exp = {48'd0, pat(5 - di), pat(di)};
      chk(got == exp, "R6 R7", got, exp);
      repeat (4 * DIV) step;
      chk(sck && ser_out, "R6 idle", {sck, ser_out}, 2'b11);
    end
    // R3 mask
    irq_en = 1'b0; step;
    chk(!irq && tx_empty, "R3 mask", {irq, tx_empty}, 2'b01);
    irq_en = 1'b1;
    // R8 R9 R10: async disable while a second byte waits
    mode = 2'b00; two_stop = 1'b0;
    wr(8'h3C); wait_empty; wr(8'hC3);
    tx_en = 1'b0; step;
    chk(tx_empty && irq, "R8", {tx_empty, irq}, 2'b11);
    cap_a(20, got);
    exp = (afr(8'hC3, 0, 0, 0) << 10) | afr(8'h3C, 0, 0, 0);
    chk(got == exp, "R9", got, exp);
    wr(8'h00);
    chk(tx_empty, "R10 empty", tx_empty, 1);
    bad = 0;
    for (int k = 0; k < 20 * DIV; k++) begin step; if (!ser_out || !tx_empty) bad++; end
    chk(bad == 0, "R10 line", bad, 0);
    // R8 R9: synchronous disable needs both enables low
    mode = 2'b10; tx_en = 1'b1; rx_en = 1'b1;
    wr(8'h96); wait_empty; wr(8'h69);
    tx_en = 1'b0; rx_en = 1'b0; step;
    chk(tx_empty, "R8 sync", tx_empty, 1);
    cap_s(16, got);
    chk(got == 64'h6996, "R9 sync", got, 64'h6996);
    repeat (4 * DIV) step;
    // R11 receive-only dummy write
    rx_en = 1'b1; step;
    wr(8'hE7);
    chk(!tx_empty, "R11 accept", tx_empty, 0);
    wait_empty;
    cap_s(8, got);
    chk(got == 64'hE7, "R11", got, 64'hE7);
    repeat (4 * DIV) step;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule